// File: doc/BRIEF.md
# Replicated Incrementer Array with XOR Compaction

This block is a scalable switching-activity load. It holds a parameterised number of 8-bit registered incrementers. Each one adds one to its own state on every clock edge. The copies are folded onto a fixed 72-bit result bus by bitwise XOR, so every copy stays observable at the block's output, however many copies there are. Copy `i` belongs to group `i mod 9`, and each group owns one 8-bit slice of the bus.

A build parameter selects a triple-redundant form. In that form every state bit lives in three lane registers. A per-bit majority vote produces the copy's value, and that voted value, plus one, is written back into all three lanes on each edge. A second parameter gives each lane its own clock input. A small upset port lets a test flip one chosen bit of one lane of one copy, to show that single faults are masked.

After reset each copy holds its own index modulo 256. The bus therefore starts non-zero and follows a fully predictable sequence.

Top module: `rix_incr_array`

## Requirements
- R1: A synchronous active-high `rst` loads copy i with i mod 256. While reset is applied, and at the first edge after it, `sig_bus` shows the XOR of these seeds per group.
- R2: On each edge without reset, every copy's value becomes its previous value plus one, modulo 256 (255 wraps to 0).
- R3: Copy i belongs to group i mod 9. Group g drives only bus bits [8g+7:8g], with the bitwise XOR of its members' values.
- R4: Changing the state of any single copy by one bit changes `sig_bus`.
- R5: In the redundant form, an upset that flips one bit of one lane leaves `sig_bus` unchanged. An upset is `upset_stb`=1 with copy index `upset_copy`, lane code `upset_lane` 0..2 and bit index `upset_bit` 0..7. Lane code 3 selects no lane.
- R6: In the redundant form, the voted value plus one is written into all three lanes. Upsets of the same bit in two different lanes on consecutive edges therefore remain masked.
- R7: In the single-register form, an upset XORs bit `upset_bit` into the selected copy's incremented value. The offset persists in later counts, and `upset_lane` is ignored.
- R8: While `upset_stb` is 0, the values on `upset_copy`, `upset_lane` and `upset_bit` have no effect on `sig_bus`.
- R9: Reset takes priority over an upset applied on the same edge.
- R10: In the three-clock form, lanes 0, 1 and 2 are clocked by `clk_a`, `clk_b` and `clk_c`. A lane that misses edges is outvoted, and it is reloaded with the voted value plus one at its next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of lane 0, and of all lanes in the single-clock forms |
| clk_b | input | 1 | Clock of lane 1 in the three-clock form |
| clk_c | input | 1 | Clock of lane 2 in the three-clock form |
| rst | input | 1 | Synchronous active-high reset to the seeds |
| upset_stb | input | 1 | Applies a one-bit upset on this edge |
| upset_copy | input | $clog2(N_COPIES) | Index of the copy to upset |
| upset_lane | input | 2 | Lane to upset (0..2; 3 selects none) |
| upset_bit | input | $clog2(CNT_W) | Bit position to flip |
| sig_bus | output | BUS_W | XOR-compacted group values |

## Verification
The assertions model the bus as a pure function of the number of edges since reset. This model is valid only under three conditions:
- At most one lane of any copy is disturbed in a cycle, by either an upset or a missed clock edge, never both.
- All lane clocks share one frequency and phase.
- In the single-register form, checking stops after the first upset.

The stimulus keeps within these limits. It upsets one lane per cycle and gates only `clk_c`, only while the clock is low and only in cycles with no upset. It also holds reset across edges of every lane clock.

// File: rtl/rix_pkg.sv
package rix_pkg;

   localparam int unsigned RIX_LANES = 3;

   // two-of-three majority on one bit
   function automatic logic rix_maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/rix_voter.sv
module rix_voter #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] lane_a,
   input  logic [W-1:0] lane_b,
   input  logic [W-1:0] lane_c,
   output logic [W-1:0] maj_o
);
   import rix_pkg::*;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign maj_o[b] = rix_maj3(lane_a[b], lane_b[b], lane_c[b]);
   end

endmodule

// File: rtl/rix_counter.sv
module rix_counter #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned ID      = 0,
   parameter int unsigned COPY_W  = 5,
   parameter int unsigned BIT_W   = 3,
   parameter bit          TMR_EN  = 1'b1,
   parameter bit          TRI_CLK = 1'b1
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              clk_c,
   input  logic              rst,
   input  logic              upset_stb,
   input  logic [COPY_W-1:0] upset_copy,
   input  logic [1:0]        upset_lane,
   input  logic [BIT_W-1:0]  upset_bit,
   output logic [CNT_W-1:0]  cnt_o
);
   import rix_pkg::*;

   localparam logic [CNT_W-1:0] SEED = CNT_W'(ID);

   logic             copy_hit;
   logic [CNT_W-1:0] flip_mask;

   assign copy_hit  = upset_stb && (upset_copy == COPY_W'(ID));
   assign flip_mask = copy_hit ? (CNT_W'(1) << upset_bit) : '0;

   if (TMR_EN) begin : g_tmr
      logic [RIX_LANES-1:0]            lane_clk;
      logic [RIX_LANES-1:0][CNT_W-1:0] lane_q;
      logic [CNT_W-1:0]                voted;

      if (TRI_CLK) begin : g_three_clk
         assign lane_clk = {clk_c, clk_b, clk_a};
      end else begin : g_one_clk
         assign lane_clk = {RIX_LANES{clk_a}};
      end

      for (genvar l = 0; l < RIX_LANES; l++) begin : g_lane
         logic [CNT_W-1:0] q;
         logic             lane_hit;
         assign lane_hit = (upset_lane == 2'(l));
         always_ff @(posedge lane_clk[l]) begin
            if (rst) q <= SEED;
            else     q <= (voted + CNT_W'(1)) ^ (lane_hit ? flip_mask : '0);
         end
         assign lane_q[l] = q;
      end

      rix_voter #(.W(CNT_W)) vote_i (
         .lane_a (lane_q[0]),
         .lane_b (lane_q[1]),
         .lane_c (lane_q[2]),
         .maj_o  (voted)
      );

      assign cnt_o = voted;
   end else begin : g_plain
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk_a) begin
         if (rst) q <= SEED;
         else     q <= (q + CNT_W'(1)) ^ flip_mask;
      end
      assign cnt_o = q;
   end

endmodule

// File: rtl/rix_xor_compactor.sv
module rix_xor_compactor #(
   parameter int unsigned N_COPIES = 27,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned N_GROUPS = 9
) (
   input  logic [N_COPIES*CNT_W-1:0] flat_i,
   output logic [N_GROUPS*CNT_W-1:0] bus_o
);

   // group g gathers copies g, g+N_GROUPS, g+2*N_GROUPS, ...
   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      logic [CNT_W-1:0] acc;
      always_comb begin
         acc = '0;
         for (int i = g; i < N_COPIES; i += N_GROUPS) begin
            acc = acc ^ flat_i[i*CNT_W +: CNT_W];
         end
      end
      assign bus_o[g*CNT_W +: CNT_W] = acc;
   end

endmodule

// File: rtl/rix_incr_array.sv
module rix_incr_array #(
   parameter int unsigned N_COPIES = 27,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned BUS_W    = 72,
   parameter bit          TMR_EN   = 1'b1,
   parameter bit          TRI_CLK  = 1'b1
) (
   input  logic                        clk_a,
   input  logic                        clk_b,
   input  logic                        clk_c,
   input  logic                        rst,
   input  logic                        upset_stb,
   input  logic [$clog2(N_COPIES)-1:0] upset_copy,
   input  logic [1:0]                  upset_lane,
   input  logic [$clog2(CNT_W)-1:0]    upset_bit,
   output logic [BUS_W-1:0]            sig_bus
);

   localparam int unsigned N_GROUPS = BUS_W / CNT_W;
   localparam int unsigned COPY_W   = $clog2(N_COPIES);
   localparam int unsigned BIT_W    = $clog2(CNT_W);

   if (CNT_W < 2 || (1 << BIT_W) != CNT_W) begin : g_bad_width
      $error("rix_incr_array: CNT_W must be a power of two >= 2");
   end
   if (N_GROUPS * CNT_W != BUS_W) begin : g_bad_bus
      $error("rix_incr_array: BUS_W must be a multiple of CNT_W");
   end
   if (N_COPIES < N_GROUPS || N_COPIES > 4096) begin : g_bad_count
      $error("rix_incr_array: N_COPIES must lie in [BUS_W/CNT_W, 4096]");
   end
   if (!TMR_EN && TRI_CLK) begin : g_bad_mode
      $error("rix_incr_array: three clocks need the redundant form");
   end

   logic [N_COPIES*CNT_W-1:0] flat;

   for (genvar i = 0; i < N_COPIES; i++) begin : g_copy
      rix_counter #(
         .CNT_W   (CNT_W),
         .ID      (i),
         .COPY_W  (COPY_W),
         .BIT_W   (BIT_W),
         .TMR_EN  (TMR_EN),
         .TRI_CLK (TRI_CLK)
      ) cnt_i (
         .clk_a      (clk_a),
         .clk_b      (clk_b),
         .clk_c      (clk_c),
         .rst        (rst),
         .upset_stb  (upset_stb),
         .upset_copy (upset_copy),
         .upset_lane (upset_lane),
         .upset_bit  (upset_bit),
         .cnt_o      (flat[i*CNT_W +: CNT_W])
      );
   end

   rix_xor_compactor #(
      .N_COPIES (N_COPIES),
      .CNT_W    (CNT_W),
      .N_GROUPS (N_GROUPS)
   ) cmp_i (
      .flat_i (flat),
      .bus_o  (sig_bus)
   );

endmodule

// File: rtl/rix_incr_array_chk.sv
module rix_incr_array_chk #(
   parameter int unsigned N_COPIES = 27,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned BUS_W    = 72,
   parameter bit          TMR_EN   = 1'b1
) (
   input logic             clk_a,
   input logic             rst,
   input logic             upset_stb,
   input logic [BUS_W-1:0] sig_bus
);

   localparam int unsigned GRP = BUS_W / CNT_W;

   logic             seen_rst = 1'b0;
   logic             upset_seen = 1'b0;
   logic [CNT_W-1:0] edges = '0;

   always_ff @(posedge clk_a) begin
      if (rst) begin
         seen_rst   <= 1'b1;
         edges      <= '0;
         upset_seen <= 1'b0;
      end else begin
         edges <= edges + CNT_W'(1);
         if (upset_stb) upset_seen <= 1'b1;
      end
   end

   function automatic logic [BUS_W-1:0] model_bus(input logic [CNT_W-1:0] k);
      logic [BUS_W-1:0] b;
      b = '0;
      for (int i = 0; i < N_COPIES; i++) begin
         b[(i % GRP)*CNT_W +: CNT_W] = b[(i % GRP)*CNT_W +: CNT_W] ^ (CNT_W'(i) + k);
      end
      return b;
   endfunction

   assert_seed_after_reset_R1: assert property (@(posedge clk_a) disable iff (rst)
      (seen_rst && $past(rst)) |-> (sig_bus == model_bus('0)));

   assert_count_track_R2: assert property (@(posedge clk_a) disable iff (rst)
      (seen_rst && (TMR_EN || !upset_seen)) |-> (sig_bus == model_bus(edges)));

   assert_upset_masked_R5: assert property (@(posedge clk_a) disable iff (rst)
      (TMR_EN && seen_rst && !$past(rst) && $past(upset_stb)) |-> (sig_bus == model_bus(edges)));

   assert_reset_beats_upset_R9: assert property (@(posedge clk_a) disable iff (rst)
      (seen_rst && $past(rst) && $past(upset_stb)) |-> (sig_bus == model_bus('0)));

endmodule

bind rix_incr_array rix_incr_array_chk #(
   .N_COPIES (N_COPIES),
   .CNT_W    (CNT_W),
   .BUS_W    (BUS_W),
   .TMR_EN   (TMR_EN)
) chk_i (
   .clk_a     (clk_a),
   .rst       (rst),
   .upset_stb (upset_stb),
   .sig_bus   (sig_bus)
);

// File: tb/rix_incr_array_tb_top.sv
module rix_incr_array_tb_top;

   localparam int CLK_P = 10;
   localparam int NC    = 27;
   localparam int GRP   = 9;

   typedef struct packed {
      logic [7:0] adv;
      logic       up;
      logic [4:0] cp;
      logic [1:0] ln;
      logic [2:0] bt;
      logic       gc;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{8'd3, 1'b0, 5'd0,  2'd0, 3'd0, 1'b1},
      '{8'd0, 1'b1, 5'd5,  2'd0, 3'd2, 1'b1},
      '{8'd0, 1'b1, 5'd5,  2'd1, 3'd2, 1'b1},
      '{8'd2, 1'b1, 5'd5,  2'd2, 3'd2, 1'b1},
      '{8'd2, 1'b1, 5'd26, 2'd1, 3'd7, 1'b1},
      '{8'd0, 1'b0, 5'd0,  2'd0, 3'd0, 1'b0},
      '{8'd2, 1'b0, 5'd0,  2'd0, 3'd0, 1'b0},
      '{8'd3, 1'b1, 5'd9,  2'd3, 3'd1, 1'b1},
      '{8'd2, 1'b1, 5'd0,  2'd0, 3'd0, 1'b1},
      '{8'd4, 1'b0, 5'd0,  2'd0, 3'd0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       gate_c = 1'b1;
   logic       clk_c_g;
   logic       rst = 1'b1;
   logic       upset_stb = 1'b0;
   logic [4:0] upset_copy = '0;
   logic [1:0] upset_lane = '0;
   logic [2:0] upset_bit = '0;
   logic [71:0] bus_t, bus_1, bus_p;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] mt [NC];
   logic [7:0] mp [NC];

   always #(CLK_P/2) clk = ~clk;
   assign clk_c_g = clk & gate_c;

   rix_incr_array #(.N_COPIES(NC), .TMR_EN(1'b1), .TRI_CLK(1'b1)) dut_i (
      .clk_a(clk), .clk_b(clk), .clk_c(clk_c_g), .rst(rst),
      .upset_stb(upset_stb), .upset_copy(upset_copy), .upset_lane(upset_lane),
      .upset_bit(upset_bit), .sig_bus(bus_t));

   rix_incr_array #(.N_COPIES(NC), .TMR_EN(1'b1), .TRI_CLK(1'b0)) dut_one_clk_i (
      .clk_a(clk), .clk_b(clk), .clk_c(clk), .rst(rst),
      .upset_stb(upset_stb), .upset_copy(upset_copy), .upset_lane(upset_lane),
      .upset_bit(upset_bit), .sig_bus(bus_1));

   rix_incr_array #(.N_COPIES(NC), .TMR_EN(1'b0), .TRI_CLK(1'b0)) dut_plain_i (
      .clk_a(clk), .clk_b(clk), .clk_c(clk), .rst(rst),
      .upset_stb(upset_stb), .upset_copy(upset_copy), .upset_lane(upset_lane),
      .upset_bit(upset_bit), .sig_bus(bus_p));

   function automatic logic [71:0] pack(input logic [7:0] a [NC]);
      logic [71:0] b;
      b = '0;
      for (int i = 0; i < NC; i++) b[(i % GRP)*8 +: 8] = b[(i % GRP)*8 +: 8] ^ a[i];
      return b;
   endfunction

   task automatic check_eq(string tag, string who, logic [71:0] act, logic [71:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
      end
   endtask

   task automatic check_ne(string tag, string who, logic [71:0] act, logic [71:0] other);
      n_chk++;
      if (act === other) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected a value other than %h", tag, who, act, other);
      end
   endtask

   task automatic tick(string tt, string t1, string tp);
      @(posedge clk);
      for (int i = 0; i < NC; i++) begin
         if (rst) begin
            mt[i] = 8'(i);
            mp[i] = 8'(i);
         end else begin
            mt[i] = mt[i] + 8'd1;
            mp[i] = (mp[i] + 8'd1) ^
                    ((upset_stb && upset_copy == 5'(i)) ? (8'd1 << upset_bit) : 8'd0);
         end
      end
      @(negedge clk);
      check_eq(tt, "three_clk", bus_t, pack(mt));
      check_eq(t1, "one_clk", bus_1, pack(mt));
      check_eq(tp, "plain", bus_p, pack(mp));
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit prev_up;
      bit any_up;
      logic [7:0]  tmp [NC];
      logic [71:0] alt;
      logic [71:0] diff;
      @(negedge clk);
      // R1: reset state
      tick("R1", "R1", "R1");
      tick("R1", "R1", "R1");
      rst = 1'b0;
      prev_up = 1'b0;
      any_up = 1'b0;
      // vector table walk (R2, R5, R6, R7, R10)
      foreach (VEC[v]) begin
         upset_stb  = VEC[v].up;
         upset_copy = VEC[v].cp;
         upset_lane = VEC[v].ln;
         upset_bit  = VEC[v].bt;
         gate_c     = VEC[v].gc;
         if (VEC[v].up) any_up = 1'b1;
         tick(VEC[v].up ? (prev_up ? "R6" : "R5") : (VEC[v].gc ? "R2" : "R10"),
              VEC[v].up ? (prev_up ? "R6" : "R5") : "R2",
              any_up ? "R7" : "R2");
         prev_up = VEC[v].up;
         upset_stb = 1'b0;
         gate_c = 1'b1;
         for (int a = 0; a < int'(VEC[v].adv); a++) begin
            tick("R2", "R2", any_up ? "R7" : "R2");
            prev_up = 1'b0;
         end
      end
      // R8: address fields move while strobe is low
      for (int j = 0; j < 20; j++) begin
         upset_copy = 5'(j);
         upset_lane = 2'(j);
         upset_bit  = 3'(j * 3);
         tick("R8", "R8", "R8");
      end
      // R4 and R3: one flip in each copy of the single-register form
      for (int c = 0; c < NC; c++) begin
         upset_stb  = 1'b1;
         upset_copy = 5'(c);
         upset_lane = 2'(c % 3);
         upset_bit  = 3'(c % 8);
         tick("R5", "R5", "R7");
         tmp = mp;
         tmp[c] = tmp[c] ^ (8'd1 << (c % 8));
         alt = pack(tmp);
         check_ne("R4", "plain", bus_p, alt);
         diff = bus_p ^ alt;
         diff[(c % GRP)*8 +: 8] = 8'd0;
         check_eq("R3", "plain_other_slices", diff, 72'd0);
      end
      upset_stb = 1'b0;
      // R2: long run covering the 255 to 0 wrap
      for (int j = 0; j < 300; j++) tick("R2", "R2", "R7");
      // R9: upset held during reset
      rst = 1'b1;
      upset_stb = 1'b1;
      upset_copy = 5'd3;
      upset_lane = 2'd0;
      upset_bit = 3'd0;
      tick("R9", "R9", "R9");
      tick("R9", "R9", "R9");
      rst = 1'b0;
      upset_stb = 1'b0;
      tick("R9", "R9", "R9");
      tick("R2", "R2", "R2");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule